// File: doc/BRIEF.md
# Spare Area Chunk Address Mapper

A NAND page's spare bytes are not kept in one contiguous memory. The controller cuts the page into 512-byte chunks and gives each chunk its own fixed-size spare buffer. Each buffer holds an even number of bytes. Any spare bytes that do not divide evenly across the buffers are kept in the final buffer. This block takes a page size, a spare size, a starting byte offset within the spare area and a transfer length. It turns that request into a sequence of bursts. Each burst names a buffer, an offset inside that buffer, a byte count and the full buffer-memory address where it starts.

A request is accepted only while the block is idle. The block first finds the per-buffer byte count and then the buffer that holds the starting offset, using one shared serial divider for both steps. After that it emits bursts on a valid/ready output. Each burst waits until the consumer takes it. A one-cycle done pulse closes every request. A request with zero bursts also gets a done pulse. The block only produces addresses and segment lengths; it does not move any data.

Top module: `spare_chunk_mapper`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken when `req_valid` and `req_ready` are both high. `req_valid` is ignored from acceptance until `done`, and `req_ready` stays low during that time.
- R2: The per-buffer byte count equals `spare_bytes / (page_bytes / 512)` with bit 0 cleared, so an odd quotient is rounded down to even.
- R3: The first burst's buffer index is `start_off / count`, clamped to 7. Its in-buffer offset is `start_off - index*count`. A count of zero places every byte in buffer 7 at offset `start_off`.
- R4: In buffers 0 to 6 a burst's length is min(count - in-buffer offset, remaining length). The next burst then starts at offset 0 of the following buffer.
- R5: In buffer 7 a burst's length is min(remaining length, 64 - in-buffer offset). The count does not limit it. Bytes past the end of that 64-byte region produce no burst, and a request starting at in-buffer offset 64 or beyond in buffer 7 produces no burst at all.
- R6: `burst_addr` equals 0x1000 + index*64 + in-buffer offset.
- R7: For a request that fits in reach, the burst lengths add up to `xfer_len`. Every burst has a non-zero length. A zero-length request gives `done` and no burst.
- R8: While `burst_valid` is high and `burst_ready` is low, `burst_valid` and all burst fields hold their values.
- R9: `done` is high for exactly one cycle. It comes on the second rising edge after the final burst's handshake edge, and it is never high together with `burst_valid`.
- R10: After reset `req_ready` is 1, `burst_valid` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request can be taken |
| page_bytes | input | PAGE_W | Page size in bytes, a multiple of 512 |
| spare_bytes | input | SPARE_W | Spare area size in bytes |
| start_off | input | SPARE_W | First spare byte of the transfer |
| xfer_len | input | LEN_W | Bytes to transfer |
| burst_valid | output | 1 | Burst fields valid |
| burst_ready | input | 1 | Consumer takes the burst |
| burst_buf | output | IDX_W | Spare buffer index |
| burst_off | output | SPARE_W | Byte offset inside that buffer |
| burst_len | output | LEN_W | Burst byte count |
| burst_addr | output | ADDR_W | Buffer-memory address of the burst's first byte |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
A wrong per-buffer count or a wrong first quotient shows up in the very first burst after the divider latency, as a wrong buffer index, offset or address. A fault in how the remaining length or the in-buffer offset advances shows up later. It appears in the next burst of the same request, either as a wrong length or as a missing or extra burst when `done` arrives. The scoreboard compares every handshake, checks that `done` arrives with an empty queue, and checks how many cycles after the last burst it comes. Each of these faults is therefore reported within one request.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SBSZ,
    ST_INDEX,
    ST_SEG,
    ST_OUT
  } scm_state_t;
endpackage

// File: rtl/scm_divider.sv
module scm_divider #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done
);
  logic [CW-1:0] cnt;
  logic          busy;
  logic [W-1:0]  q_r, r_r, d_r, n_r;
  logic [W:0]    trial, diff;

  assign trial = {r_r, q_r[W-1]};
  assign diff  = trial - {1'b0, d_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      q_r  <= '0;
      r_r  <= '0;
      d_r  <= '0;
      n_r  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= CW'(W);
        q_r  <= dividend;
        n_r  <= dividend;
        r_r  <= '0;
        d_r  <= divisor;
      end else if (busy) begin
        if (!diff[W]) begin
          r_r <= diff[W-1:0];
          q_r <= {q_r[W-2:0], 1'b1};
        end else begin
          r_r <= trial[W-1:0];
          q_r <= {q_r[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient  = q_r;
  assign remainder = r_r;

  logic [2*W-1:0] recon;
  assign recon = {{W{1'b0}}, q_r} * {{W{1'b0}}, d_r} + {{W{1'b0}}, r_r};

  // R2 and R3 both rest on an exact quotient and remainder
  a_r3_quotient: assert property (@(posedge clk) disable iff (rst)
    (done && d_r != '0) |-> (recon == {{W{1'b0}}, n_r} && r_r < d_r));
  a_r3_busy_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/scm_segment.sv
module scm_segment #(
  parameter int SPARE_W = 8,
  parameter int LEN_W   = 9,
  parameter int NBUF    = 8,
  parameter int REGION  = 64,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h1000,
  localparam int IDX_W  = $clog2(NBUF),
  localparam int REG_SH = $clog2(REGION)
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [SPARE_W-1:0] inoff,
  input  logic [SPARE_W-1:0] per_buf,
  input  logic [LEN_W-1:0]   remain,
  output logic               has_room,
  output logic [LEN_W-1:0]   seg_len,
  output logic [ADDR_W-1:0]  seg_addr
);
  logic             last;
  logic [LEN_W-1:0] room;

  assign last = (idx == IDX_W'(NBUF - 1));

  always_comb begin
    if (last) begin
      if (LEN_W'(inoff) >= LEN_W'(REGION)) room = '0;
      else                                  room = LEN_W'(REGION) - LEN_W'(inoff);
    end else begin
      room = LEN_W'(per_buf) - LEN_W'(inoff);
    end
  end

  assign has_room = (room != '0);
  assign seg_len  = (remain < room) ? remain : room;
  assign seg_addr = BASE + (ADDR_W'(idx) << REG_SH) + ADDR_W'(inoff);
endmodule

// File: rtl/spare_chunk_mapper.sv
module spare_chunk_mapper
  import scm_pkg::*;
#(
  parameter int PAGE_W  = 16,
  parameter int SPARE_W = 8,
  parameter int LEN_W   = 9,
  parameter int NBUF    = 8,
  parameter int REGION  = 64,
  parameter int CHUNK   = 512,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h1000,
  localparam int IDX_W    = $clog2(NBUF),
  localparam int CHUNK_SH = $clog2(CHUNK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PAGE_W-1:0]  page_bytes,
  input  logic [SPARE_W-1:0] spare_bytes,
  input  logic [SPARE_W-1:0] start_off,
  input  logic [LEN_W-1:0]   xfer_len,
  output logic               burst_valid,
  input  logic               burst_ready,
  output logic [IDX_W-1:0]   burst_buf,
  output logic [SPARE_W-1:0] burst_off,
  output logic [LEN_W-1:0]   burst_len,
  output logic [ADDR_W-1:0]  burst_addr,
  output logic               done
);
  scm_state_t st;

  logic [SPARE_W-1:0] off_q, sb_q, inoff_q;
  logic [LEN_W-1:0]   len_q;
  logic [IDX_W-1:0]   idx_q;

  logic               div_start;
  logic [SPARE_W-1:0] div_a, div_b, div_q, div_r;
  logic               div_done;
  logic [SPARE_W-1:0] sb_next;

  logic               seg_room;
  logic [LEN_W-1:0]   seg_len;
  logic [ADDR_W-1:0]  seg_addr;

  scm_divider #(.W(SPARE_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (div_a),
    .divisor  (div_b),
    .quotient (div_q),
    .remainder(div_r),
    .done     (div_done)
  );

  scm_segment #(
    .SPARE_W(SPARE_W), .LEN_W(LEN_W), .NBUF(NBUF),
    .REGION(REGION), .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_seg (
    .idx     (idx_q),
    .inoff   (inoff_q),
    .per_buf (sb_q),
    .remain  (len_q),
    .has_room(seg_room),
    .seg_len (seg_len),
    .seg_addr(seg_addr)
  );

  assign sb_next   = {div_q[SPARE_W-1:1], 1'b0};
  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      off_q       <= '0;
      sb_q        <= '0;
      inoff_q     <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      div_start   <= 1'b0;
      div_a       <= '0;
      div_b       <= '0;
      burst_valid <= 1'b0;
      burst_buf   <= '0;
      burst_off   <= '0;
      burst_len   <= '0;
      burst_addr  <= '0;
      done        <= 1'b0;
    end else begin
      div_start <= 1'b0;
      done      <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            off_q     <= start_off;
            len_q     <= xfer_len;
            div_a     <= spare_bytes;
            div_b     <= SPARE_W'(page_bytes >> CHUNK_SH);
            div_start <= 1'b1;
            st        <= ST_SBSZ;
          end
        end
        ST_SBSZ: begin
          if (div_done) begin
            sb_q      <= sb_next;
            div_a     <= off_q;
            div_b     <= sb_next;
            div_start <= 1'b1;
            st        <= ST_INDEX;
          end
        end
        ST_INDEX: begin
          if (div_done) begin
            if (div_q > SPARE_W'(NBUF - 1)) begin
              idx_q   <= IDX_W'(NBUF - 1);
              inoff_q <= off_q - SPARE_W'((NBUF - 1) * sb_q);
            end else begin
              idx_q   <= IDX_W'(div_q);
              inoff_q <= div_r;
            end
            st <= ST_SEG;
          end
        end
        ST_SEG: begin
          if (len_q == '0 || !seg_room) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            burst_valid <= 1'b1;
            burst_buf   <= idx_q;
            burst_off   <= inoff_q;
            burst_len   <= seg_len;
            burst_addr  <= seg_addr;
            st          <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (burst_ready) begin
            burst_valid <= 1'b0;
            len_q       <= len_q - burst_len;
            if (idx_q == IDX_W'(NBUF - 1)) begin
              inoff_q <= inoff_q + SPARE_W'(burst_len);
            end else begin
              idx_q   <= idx_q + 1'b1;
              inoff_q <= '0;
            end
            st <= ST_SEG;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && !burst_ready) |=> (burst_valid && $stable(burst_buf) &&
      $stable(burst_off) && $stable(burst_len) && $stable(burst_addr)));
  a_r1_busy: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> !req_ready);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    done |-> !burst_valid);
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_nonzero: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> burst_len != '0);
  a_r5_region: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && burst_buf == IDX_W'(NBUF - 1)) |->
      ((LEN_W + 1)'(burst_off) + (LEN_W + 1)'(burst_len) <= (LEN_W + 1)'(REGION)));
  a_r4_inbuf: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && burst_buf != IDX_W'(NBUF - 1)) |->
      ((LEN_W + 1)'(burst_off) + (LEN_W + 1)'(burst_len) <= (LEN_W + 1)'(sb_q)));
endmodule

// File: tb/spare_chunk_mapper_test.sv
module spare_chunk_mapper_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] page_bytes = '0;
  logic [7:0]  spare_bytes = '0;
  logic [7:0]  start_off = '0;
  logic [8:0]  xfer_len = '0;
  logic        burst_valid;
  logic        burst_ready = 1'b1;
  logic [2:0]  burst_buf;
  logic [7:0]  burst_off;
  logic [8:0]  burst_len;
  logic [15:0] burst_addr;
  logic        done;

  spare_chunk_mapper uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .page_bytes(page_bytes), .spare_bytes(spare_bytes), .start_off(start_off),
    .xfer_len(xfer_len), .burst_valid(burst_valid), .burst_ready(burst_ready),
    .burst_buf(burst_buf), .burst_off(burst_off), .burst_len(burst_len),
    .burst_addr(burst_addr), .done(done)
  );

  always #5 clk = ~clk;

  typedef struct { int b; int o; int l; int a; } exp_t;
  exp_t expq[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_hs = 0;
  int n_bursts = 0;
  bit bp_on = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    burst_ready = bp_on ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pop and R8 hold check
  bit   hold_pend = 1'b0;
  exp_t held;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        chk(burst_valid == 1'b1, "R8 valid held", int'(burst_valid), 1);
        chk(int'(burst_addr) == held.a && int'(burst_len) == held.l &&
            int'(burst_off) == held.o && int'(burst_buf) == held.b,
            "R8 fields held", int'(burst_addr), held.a);
      end
      if (burst_valid && burst_ready) begin
        hold_pend = 1'b0;
        last_hs = cyc;
        if (expq.size() == 0) begin
          chk(1'b0, "R7 unexpected burst", int'(burst_len), 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(int'(burst_buf) == e.b, "R3/R4 buffer index", int'(burst_buf), e.b);
          chk(int'(burst_off) == e.o, "R3/R4 in-buffer offset", int'(burst_off), e.o);
          chk(int'(burst_len) == e.l, "R4/R5 burst length", int'(burst_len), e.l);
          chk(int'(burst_addr) == e.a, "R6 burst address", int'(burst_addr), e.a);
        end
      end else if (burst_valid) begin
        hold_pend = 1'b1;
        held.b = int'(burst_buf); held.o = int'(burst_off);
        held.l = int'(burst_len); held.a = int'(burst_addr);
      end else begin
        hold_pend = 1'b0;
      end
    end
  end

  // Driver: reference model pushes the expected bursts, then drives the request
  task automatic run_req(input int page, input int spare, input int off,
                         input int len, input bit stray);
    int chunks, sb, idx, io, rem, room, seg;
    exp_t e;
    chunks = page / 512;
    sb = (spare / chunks) & ~1;   // R2
    if (sb == 0) begin idx = 7; io = off; end
    else begin
      idx = off / sb;
      if (idx > 7) idx = 7;
      io = off - idx * sb;
    end
    rem = len;
    n_bursts = 0;
    while (rem > 0) begin
      if (idx == 7) room = (io >= 64) ? 0 : 64 - io;
      else          room = sb - io;
      if (room == 0) break;
      seg = (rem < room) ? rem : room;
      e.b = idx; e.o = io; e.l = seg; e.a = 4096 + idx * 64 + io;
      expq.push_back(e);
      n_bursts++;
      rem -= seg;
      if (idx == 7) io += seg;
      else begin idx++; io = 0; end
    end
    while (!req_ready) @(negedge clk);
    req_valid   = 1'b1;
    page_bytes  = 16'(page);
    spare_bytes = 8'(spare);
    start_off   = 8'(off);
    xfer_len    = 9'(len);
    @(negedge clk);
    if (stray) begin
      // R1: a second request during the busy phase must be ignored
      page_bytes = 16'd512; spare_bytes = 8'd16; start_off = 8'd0; xfer_len = 9'd3;
      for (int k = 0; k < 5; k++) begin
        chk(req_ready == 1'b0, "R1 ready low while busy", int'(req_ready), 0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(expq.size() == 0, "R7 all bursts seen at done", expq.size(), 0);
    chk(burst_valid == 1'b0, "R9 done without burst_valid", int'(burst_valid), 0);
    if (n_bursts > 0)
      chk(cyc - last_hs == 2, "R9 done timing", cyc - last_hs, 2);
    expq.delete();
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset req_ready", int'(req_ready), 1);
    chk(burst_valid == 1'b0, "R10 reset burst_valid", int'(burst_valid), 0);
    chk(done == 1'b0, "R10 reset done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 idle after reset", int'(req_ready), 1);
    run_req(2048, 64, 5, 40, 1'b0);    // R2 R3 R4 R6: three buffers
    run_req(512, 16, 0, 16, 1'b0);     // single full buffer
    run_req(4096, 218, 180, 38, 1'b0); // R2 odd rounding, spill into last
    run_req(8192, 128, 100, 30, 1'b0); // R3 clamp, R5 truncation at region end
    run_req(2048, 64, 10, 0, 1'b0);    // R7 zero length
    run_req(8192, 128, 200, 5, 1'b0);  // R5 start beyond last region: no burst
    run_req(8192, 16, 4, 10, 1'b0);    // R3 zero per-buffer count
    bp_on = 1'b1;
    run_req(2048, 64, 0, 64, 1'b1);    // R1 stray request, R8 back-pressure
    run_req(4096, 128, 3, 120, 1'b0);  // R4 R5 long walk under back-pressure
    run_req(4096, 218, 0, 218, 1'b0);  // R5 leftover bytes in last buffer
    bp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule